// File: doc/BRIEF.md
# Packet Transmit Buffer Engine

This engine moves 16-bit words from a memory buffer to an output shift register. Software describes the buffer with a control block in memory. The control block holds a transmit pointer, a limit and two completion slots. Each completion slot is a status word followed by an interrupt mask word. When the shifter asks for data by raising its ready wakeup, the engine clears the wakeup and reads the pointer and the limit as a pair. If words remain, it loads the word at the pointer into the shifter and writes the advanced pointer back. If the buffer is exhausted, it posts completion instead.

A control-set command sets the control block base. The command carries an argument address, which becomes the new base. The word found at that address sets the last-chunk flag, and the command then posts completion. When the last-chunk flag is set, loading the final word of a buffer also raises an end-of-packet control function. Completion is posted on the wakeup that follows the last word, not when the last word is sent.

Four wakeup sources share one sequencer: control-set, input word, output word and start input. The two receive-side wakeups are only arbitrated here. They are handed to a receive engine through a grant pulse.

Top module: `pkt_tx_engine`

## Requirements
- R1: After a synchronous reset, every strobe output is low, `irq_pend` is zero and the last-chunk flag is clear.
- R2: Wakeups that are pending together are served one at a time in this fixed order: control-set (`ctl_clr` pulse), input word (`rx_grant` bit 1), output word (`tx_clr` pulse), start input (`rx_grant` bit 0). At most one of these four indications is high in any cycle.
- R3: A control-set wakeup pulses `ctl_clr`, takes `ctl_arg` as the new control block base, copies bit 0 of the memory word at that address into the last-chunk flag, and posts done at base + 6.
- R4: An output wakeup pulses `tx_clr`, then reads the pointer at base + 4 and the limit at base + 5.
- R5: When the pointer differs from the limit, `ld_stb` pulses for exactly one cycle with `ld_data` equal to the memory word at the pointer. The pulse is raised only in a cycle that follows `sh_idle` being high. The engine waits for as long as the shifter is busy. Pointer + 1 is then written to base + 4.
- R6: When the pointer equals the limit, no word is loaded, the pointer is left unchanged, and done is posted at base + 10.
- R7: `ctl_fn_stb` pulses with `ctl_fn_val` = 2, in the same cycle as `ld_stb`, exactly when the loaded word sat at limit − 1 and the last-chunk flag is set. It never pulses otherwise.
- R8: A post reads the word that follows the status slot, at slot + 1, and ORs it into `irq_pend`.
- R9: The status word a post writes is the done code 0x01FF ANDed with `hw_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wake | input | 1 | Control-set command pending |
| ctl_arg | input | AW | Argument address of the control-set command |
| rx_start_wake | input | 1 | Start-input wakeup |
| rx_word_wake | input | 1 | Input-word wakeup |
| tx_wake | input | 1 | Shifter requests a word |
| sh_idle | input | 1 | Shifter is idle and can accept a load |
| hw_status | input | DW | Hardware status ANDed into posted codes |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, one cycle after the request |
| ctl_clr | output | 1 | Clears the control-set wakeup |
| tx_clr | output | 1 | Clears the output wakeup |
| rx_grant | output | 2 | Receive dispatch: bit 1 input word, bit 0 start input |
| ld_stb | output | 1 | Load strobe to the shifter |
| ld_data | output | DW | Word loaded into the shifter |
| ctl_fn_stb | output | 1 | Control-function strobe |
| ctl_fn_val | output | 2 | Control-function value (2 = end of packet) |
| irq_pend | output | DW | Accumulated interrupt bits |

## Verification
The bench drains a three-word buffer with the last-chunk flag set. It then drains the same final word with the flag clear. A design that marked every word, or that ignored the flag, would show an end-of-packet strobe in the wrong place. The bench holds the shifter busy across a wakeup, so a design that loads without waiting would produce a word while the shifter is still busy. It follows the last word with one more wakeup on the exhausted buffer. That wakeup must post a masked status and leave the pointer alone, so a design that posted early or ran past the limit would corrupt the pointer or the slot. Finally, all four wakeups are raised in the same cycle, and the bench compares the order in which they are served against the fixed priority.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_RXW, SEL_TX, SEL_RXS
  } sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_C1, S_C2,
    S_T1, S_T2, S_T3, S_T4, S_T5, S_T6,
    S_P1, S_P2, S_P3, S_P4
  } st_e;

  localparam int OFF_PTR   = 4;
  localparam int OFF_LIM   = 5;
  localparam int OFF_CPOST = 6;
  localparam int OFF_TPOST = 10;
  localparam int DONE_CODE = 'h1FF;
  localparam int FN_EOP    = 2;
endpackage

// File: rtl/pkt_tx_arb.sv
module pkt_tx_arb
  import pkt_tx_pkg::*;
(
  input  logic ctl_req,
  input  logic rxw_req,
  input  logic tx_req,
  input  logic rxs_req,
  output sel_e sel
);
  always_comb begin
    if (ctl_req)      sel = SEL_CTL;
    else if (rxw_req) sel = SEL_RXW;
    else if (tx_req)  sel = SEL_TX;
    else if (rxs_req) sel = SEL_RXS;
    else              sel = SEL_NONE;
  end
endmodule

// File: rtl/pkt_tx_cmp.sv
module pkt_tx_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] lim,
  output logic          empty,
  output logic          final_word
);
  assign empty      = (ptr == lim);
  assign final_word = (ptr + DW'(1) == lim);
endmodule

// File: rtl/pkt_tx_engine.sv
module pkt_tx_engine
  import pkt_tx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wake,
  input  logic [AW-1:0] ctl_arg,
  input  logic          rx_start_wake,
  input  logic          rx_word_wake,
  input  logic          tx_wake,
  input  logic          sh_idle,
  input  logic [DW-1:0] hw_status,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          ctl_clr,
  output logic          tx_clr,
  output logic [1:0]    rx_grant,
  output logic          ld_stb,
  output logic [DW-1:0] ld_data,
  output logic          ctl_fn_stb,
  output logic [1:0]    ctl_fn_val,
  output logic [DW-1:0] irq_pend
);
  localparam logic [DW-1:0] DONE_W = DW'(DONE_CODE);

  st_e           st;
  sel_e          sel;
  logic [AW-1:0] base;
  logic [AW-1:0] post_off;
  logic [DW-1:0] ptr;
  logic [DW-1:0] word;
  logic          last_chunk;
  logic          is_final;
  logic          empty;
  logic          final_word;

  pkt_tx_arb u_arb (
    .ctl_req (ctl_wake),
    .rxw_req (rx_word_wake),
    .tx_req  (tx_wake),
    .rxs_req (rx_start_wake),
    .sel     (sel)
  );

  pkt_tx_cmp #(.DW(DW)) u_cmp (
    .ptr        (ptr),
    .lim        (mem_rdata),
    .empty      (empty),
    .final_word (final_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      base       <= '0;
      post_off   <= '0;
      ptr        <= '0;
      word       <= '0;
      last_chunk <= 1'b0;
      is_final   <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      ctl_clr    <= 1'b0;
      tx_clr     <= 1'b0;
      rx_grant   <= '0;
      ld_stb     <= 1'b0;
      ld_data    <= '0;
      ctl_fn_stb <= 1'b0;
      ctl_fn_val <= '0;
      irq_pend   <= '0;
    end else begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      ctl_clr    <= 1'b0;
      tx_clr     <= 1'b0;
      rx_grant   <= '0;
      ld_stb     <= 1'b0;
      ctl_fn_stb <= 1'b0;
      ctl_fn_val <= '0;
      unique case (st)
        S_IDLE: begin
          unique case (sel)
            SEL_CTL: begin
              base     <= ctl_arg;
              mem_req  <= 1'b1;
              mem_addr <= ctl_arg;
              ctl_clr  <= 1'b1;
              st       <= S_C1;
            end
            SEL_RXW: begin
              rx_grant <= 2'b10;
              st       <= S_GAP;
            end
            SEL_TX: begin
              mem_req  <= 1'b1;
              mem_addr <= base + AW'(OFF_PTR);
              tx_clr   <= 1'b1;
              st       <= S_T1;
            end
            SEL_RXS: begin
              rx_grant <= 2'b01;
              st       <= S_GAP;
            end
            default: st <= S_IDLE;
          endcase
        end
        S_GAP: st <= S_IDLE;
        S_C1:  st <= S_C2;
        S_C2: begin
          last_chunk <= mem_rdata[0];
          post_off   <= AW'(OFF_CPOST);
          st         <= S_P1;
        end
        S_T1: begin
          mem_req  <= 1'b1;
          mem_addr <= base + AW'(OFF_LIM);
          st       <= S_T2;
        end
        S_T2: begin
          ptr <= mem_rdata;
          st  <= S_T3;
        end
        S_T3: begin
          if (empty) begin
            post_off <= AW'(OFF_TPOST);
            st       <= S_P1;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= ptr[AW-1:0];
            is_final <= final_word;
            st       <= S_T4;
          end
        end
        S_T4: st <= S_T5;
        S_T5: begin
          word <= mem_rdata;
          st   <= S_T6;
        end
        S_T6: begin
          if (sh_idle) begin
            ld_stb    <= 1'b1;
            ld_data   <= word;
            if (is_final && last_chunk) begin
              ctl_fn_stb <= 1'b1;
              ctl_fn_val <= 2'(FN_EOP);
            end
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= base + AW'(OFF_PTR);
            mem_wdata <= ptr + DW'(1);
            st        <= S_IDLE;
          end
        end
        S_P1: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= base + post_off;
          mem_wdata <= DONE_W & hw_status;
          st        <= S_P2;
        end
        S_P2: begin
          mem_req  <= 1'b1;
          mem_addr <= base + post_off + AW'(1);
          st       <= S_P3;
        end
        S_P3: st <= S_P4;
        S_P4: begin
          irq_pend <= irq_pend | mem_rdata;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_tx_engine_chk.sv
module pkt_tx_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sh_idle,
  input logic          ctl_clr,
  input logic          tx_clr,
  input logic [1:0]    rx_grant,
  input logic          ld_stb,
  input logic          ctl_fn_stb,
  input logic [1:0]    ctl_fn_val,
  input logic [DW-1:0] irq_pend
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ld_stb && !ctl_fn_stb && irq_pend == '0)); // R1
  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (rst) $countones({ctl_clr, tx_clr, rx_grant}) <= 1); // R2
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(ld_stb) |-> $past(sh_idle)); // R5
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst) ld_stb |=> !ld_stb); // R5
  AST_EOP_WITH_LOAD: assert property (@(posedge clk) disable iff (rst) ctl_fn_stb |-> (ld_stb && ctl_fn_val == 2'd2)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) (($past(irq_pend) & ~irq_pend) == '0)); // R8
endmodule

bind pkt_tx_engine pkt_tx_engine_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sh_idle    (sh_idle),
  .ctl_clr    (ctl_clr),
  .tx_clr     (tx_clr),
  .rx_grant   (rx_grant),
  .ld_stb     (ld_stb),
  .ctl_fn_stb (ctl_fn_stb),
  .ctl_fn_val (ctl_fn_val),
  .irq_pend   (irq_pend)
);

// File: tb/pkt_tx_engine_test.sv
`timescale 1ns/1ps
module pkt_tx_engine_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wake = 1'b0, rx_start_wake = 1'b0, rx_word_wake = 1'b0, tx_wake = 1'b0;
  logic [AW-1:0] ctl_arg = '0;
  logic sh_idle = 1'b1;
  logic [DW-1:0] hw_status = 16'hFFFF;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic ctl_clr, tx_clr, ld_stb, ctl_fn_stb;
  logic [1:0] rx_grant, ctl_fn_val;
  logic [DW-1:0] ld_data, irq_pend;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW:0] exp_q [$];
  int ev_log [$];
  int tests = 0, fails = 0, loads = 0, ctl_clrs = 0;

  always #4 clk = ~clk;

  pkt_tx_engine #(.AW(AW), .DW(DW)) uut (.*);

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req) mem_rdata <= mem[mem_addr];
    if (ctl_clr) ctl_wake <= 1'b0;
    if (tx_clr) tx_wake <= 1'b0;
    if (rx_grant[1]) rx_word_wake <= 1'b0;
    if (rx_grant[0]) rx_start_wake <= 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected loads from the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (ctl_clr) begin ctl_clrs++; ev_log.push_back(1); end
      if (rx_grant[1]) ev_log.push_back(2);
      if (tx_clr) ev_log.push_back(3);
      if (rx_grant[0]) ev_log.push_back(4);
      if (ctl_fn_stb && !ld_stb) check("R7 fn without load", 0, 1);
      if (ld_stb) begin
        loads++;
        if (exp_q.size() == 0) check("R5 unexpected load", {16'h0, ld_data}, 0);
        else begin
          logic [DW:0] e;
          e = exp_q.pop_front();
          check("R5 load data", {16'h0, ld_data}, {16'h0, e[DW-1:0]});
          check("R7 end-of-packet", {31'h0, ctl_fn_stb}, {31'h0, e[DW]});
          if (ctl_fn_stb) check("R7 fn value", {30'h0, ctl_fn_val}, 2);
        end
      end
    end
  end

  task automatic push_exp(input logic [DW-1:0] w, input logic eop);
    exp_q.push_back({eop, w});
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    mem[8'h20] = 16'h0001;
    mem[8'h24] = 16'h0040; mem[8'h25] = 16'h0043;
    mem[8'h27] = 16'h0001; mem[8'h2B] = 16'h0004;
    mem[8'h40] = 16'hA1A1; mem[8'h41] = 16'hB2B2; mem[8'h42] = 16'hC3C3;
    idle_cycles(3);
    rst = 1'b0;
    idle_cycles(1);
    check("R1 ld_stb", {31'h0, ld_stb}, 0);
    check("R1 irq_pend", {16'h0, irq_pend}, 0);
    check("R1 fn", {31'h0, ctl_fn_stb}, 0);

    ctl_arg = 8'h20; ctl_wake = 1'b1;
    idle_cycles(20);
    check("R3 ctl_clr pulse", ctl_clrs, 1);
    check("R3 post at base+6", {16'h0, mem[8'h26]}, 32'h1FF);
    check("R8 irq after ctl", {16'h0, irq_pend}, 1);

    sh_idle = 1'b0; tx_wake = 1'b1;
    idle_cycles(30);
    check("R4 tx_wake cleared", {31'h0, tx_wake}, 0);
    check("R5 no load while busy", loads, 0);
    push_exp(16'hA1A1, 1'b0);
    sh_idle = 1'b1;
    idle_cycles(20);
    check("R5 pointer written back", {16'h0, mem[8'h24]}, 32'h41);
    push_exp(16'hB2B2, 1'b0); tx_wake = 1'b1; idle_cycles(20);
    push_exp(16'hC3C3, 1'b1); tx_wake = 1'b1; idle_cycles(20);
    check("R5 pointer at limit", {16'h0, mem[8'h24]}, 32'h43);
    check("R5 load count", loads, 3);

    hw_status = 16'h00F0; tx_wake = 1'b1; idle_cycles(25);
    check("R6 no load when empty", loads, 3);
    check("R6 pointer unchanged", {16'h0, mem[8'h24]}, 32'h43);
    check("R9 masked status at base+10", {16'h0, mem[8'h2A]}, 32'hF0);
    check("R8 irq accumulates", {16'h0, irq_pend}, 5);

    hw_status = 16'hFFFF; mem[8'h20] = 16'h0000;
    ctl_wake = 1'b1; idle_cycles(20);
    mem[8'h24] = 16'h0042;
    push_exp(16'hC3C3, 1'b0); tx_wake = 1'b1; idle_cycles(20);
    check("R7 last word without flag", loads, 4);

    ev_log.delete();
    rx_start_wake = 1'b1; rx_word_wake = 1'b1; tx_wake = 1'b1; ctl_wake = 1'b1;
    idle_cycles(60);
    check("R2 dispatch count", ev_log.size(), 4);
    if (ev_log.size() == 4) begin
      check("R2 first ctl", ev_log[0], 1);
      check("R2 second input word", ev_log[1], 2);
      check("R2 third output", ev_log[2], 3);
      check("R2 fourth start input", ev_log[3], 4);
    end
    check("R5 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule